// File: doc/BRIEF.md
# Register-Driven Configuration Port Writer

This block bridges a host programmed-I/O write path to an on-chip FPGA configuration port. The host writes one configuration data unit to a push address. The block then presents that unit on the port's parallel data bus for a single cycle, with the active-low chip select asserted and the read/write select held at its write level. Every clock edge that sees chip select low moves one word into the port, so one host write becomes exactly one port transfer.

Before a unit is driven onto the bus, its bits are mirrored inside each byte. The bus can be 8, 16 or 32 bits wide.

By default the block never looks at the port's busy output. A build-time option makes the block hold chip select and the data word for as long as busy is high. A 32-bit count of completed transfers can be read back, and a control bit clears it. A status word shows whether a word is in flight and the live busy level. The port's data-out bus can also be read back.

Top module: `cfgport_writer`

## Requirements
- R1: A host write (hst_we=1) to address 0 drives cfg_cs_n low in the cycle after the write edge. In the default mode chip select is low for exactly that one cycle. Writes on N consecutive cycles give N consecutive low cycles, each with its own word.
- R2: Data bit 8*b+i of cfg_din equals bit 8*b+7-i of hst_wdata, for every byte b and bit i in 0..7. Only the low DATA_W bits of hst_wdata are used.
- R3: DATA_W may be 8, 16 or 32, and R2 holds at each of these widths.
- R4: Outside reset, cfg_rdwr_n is low (write level). Chip select is never low while cfg_rdwr_n is high.
- R5: cfg_cs_n is high in every cycle that follows an edge with no accepted push and no held word, so idle cycles push no data.
- R6: With WAIT_ON_BUSY=0, cfg_busy has no effect: chip select still rises after one cycle.
- R7: With WAIT_ON_BUSY=1, while cfg_cs_n is low and cfg_busy is high, chip select stays low and cfg_din stays unchanged. A push that arrives during this hold is dropped. The word completes on the first edge with busy low.
- R8: Reading address 2 returns the transfer count. The count rises by one for each edge at which chip select is low and the word is not held.
- R9: A write to address 1 with bit 0 set clears the count. The clear wins over a transfer that completes on the same edge. A write to address 1 with bit 0 clear changes nothing.
- R10: Reading address 3 returns bit 0 = word in flight (chip select low) and bit 1 = cfg_busy, with the other bits 0. Reading address 4 returns cfg_dout, zero-extended. Any other read address returns 0.
- R11: A synchronous active-high rst drives cfg_cs_n and cfg_rdwr_n high and clears the count.
- R12: A host write to any address other than 0 does not lower chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and port clock, at most 100 MHz |
| rst | input | 1 | Synchronous active-high reset |
| hst_we | input | 1 | Host write strobe |
| hst_waddr | input | ADDR_W | Host write address |
| hst_wdata | input | 32 | Host write data |
| hst_raddr | input | ADDR_W | Host read address |
| hst_rdata | output | 32 | Host read data, combinational from hst_raddr |
| cfg_cs_n | output | 1 | Port chip select, active low |
| cfg_rdwr_n | output | 1 | Port read/write select, low = write |
| cfg_din | output | DATA_W | Byte-mirrored data into the port |
| cfg_dout | input | DATA_W | Data-out bus of the port |
| cfg_busy | input | 1 | Port busy flag |

## Verification
Chip select and the mirrored word appear one edge after the write edge. The count shows a completed transfer one edge after the cycle in which chip select was low. A clear shows up one edge after its write. Status and readback values follow hst_raddr in the same cycle. The bench drives every input on the falling clock edge and samples one falling edge after the rising edge that should produce the result. Register reads are sampled a short delay after the address is set. Instances at 8, 16 and 32 bits share one stimulus stream, with the 32-bit instance built in the busy-hold mode, so the same busy pulse checks both the ignore and the hold behaviour.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
    // host register addresses (word index)
    localparam int unsigned ADR_PUSH   = 0;
    localparam int unsigned ADR_CTRL   = 1;
    localparam int unsigned ADR_COUNT  = 2;
    localparam int unsigned ADR_STATUS = 3;
    localparam int unsigned ADR_PORTRD = 4;

    // bit positions
    localparam int unsigned CTRL_CLR_BIT    = 0;
    localparam int unsigned STAT_FLIGHT_BIT = 0;
    localparam int unsigned STAT_BUSY_BIT   = 1;

    localparam int unsigned HOST_W = 32;
endpackage

// File: rtl/cfgw_bitrev.sv
module cfgw_bitrev #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int NBYTES = DATA_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign word_o[8*b+i] = word_i[8*b+7-i];
        end
    end
endmodule

// File: rtl/cfgw_xfer_ctr.sv
module cfgw_xfer_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/cfgw_host_if.sv
module cfgw_host_if
    import cfgw_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 32
) (
    input  logic              hst_we,
    input  logic [ADDR_W-1:0] hst_waddr,
    input  logic              ctrl_clr_bit,
    input  logic [ADDR_W-1:0] hst_raddr,
    input  logic              in_flight,
    input  logic              busy,
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-1:0] port_rd,
    output logic              push_req,
    output logic              clr_req,
    output logic [HOST_W-1:0] rdata
);
    assign push_req = hst_we && (hst_waddr == ADDR_W'(ADR_PUSH));
    assign clr_req  = hst_we && (hst_waddr == ADDR_W'(ADR_CTRL)) && ctrl_clr_bit;

    always_comb begin
        rdata = '0;
        case (hst_raddr)
            ADDR_W'(ADR_COUNT): rdata = HOST_W'(count);
            ADDR_W'(ADR_STATUS): begin
                rdata[STAT_FLIGHT_BIT] = in_flight;
                rdata[STAT_BUSY_BIT]   = busy;
            end
            ADDR_W'(ADR_PORTRD): rdata = HOST_W'(port_rd);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfgport_writer.sv
module cfgport_writer
    import cfgw_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter bit WAIT_ON_BUSY = 1'b0,
    parameter int ADDR_W       = 4,
    parameter int CNT_W        = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_we,
    input  logic [ADDR_W-1:0] hst_waddr,
    input  logic [31:0]       hst_wdata,
    input  logic [ADDR_W-1:0] hst_raddr,
    output logic [31:0]       hst_rdata,
    output logic              cfg_cs_n,
    output logic              cfg_rdwr_n,
    output logic [DATA_W-1:0] cfg_din,
    input  logic [DATA_W-1:0] cfg_dout,
    input  logic              cfg_busy
);
    typedef struct packed {
        logic              cs_n;
        logic              rdwr_n;
        logic [DATA_W-1:0] din;
    } port_st_t;

    port_st_t          st_d, st_q;
    logic              push_req;
    logic              clr_req;
    logic              stall;
    logic              accept;
    logic [DATA_W-1:0] rev_word;
    logic [CNT_W-1:0]  xfer_count;

    if (DATA_W < 32) begin : g_fold
        logic unused_hi;
        assign unused_hi = ^hst_wdata[31:DATA_W];
    end

    cfgw_host_if #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_host (
        .hst_we      (hst_we),
        .hst_waddr   (hst_waddr),
        .ctrl_clr_bit(hst_wdata[CTRL_CLR_BIT]),
        .hst_raddr   (hst_raddr),
        .in_flight   (!st_q.cs_n),
        .busy        (cfg_busy),
        .count       (xfer_count),
        .port_rd     (cfg_dout),
        .push_req    (push_req),
        .clr_req     (clr_req),
        .rdata       (hst_rdata)
    );

    cfgw_bitrev #(.DATA_W(DATA_W)) u_rev (
        .word_i(hst_wdata[DATA_W-1:0]),
        .word_o(rev_word)
    );

    // a word in flight is held only in the busy-aware build
    assign stall  = WAIT_ON_BUSY && !st_q.cs_n && cfg_busy;
    assign accept = !st_q.cs_n && !stall;

    always_comb begin
        st_d        = st_q;
        st_d.rdwr_n = 1'b0;
        if (stall) begin
            st_d.cs_n = 1'b0;
        end else if (push_req) begin
            st_d.cs_n = 1'b0;
            st_d.din  = rev_word;
        end else begin
            st_d.cs_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cs_n   <= 1'b1;
            st_q.rdwr_n <= 1'b1;
            st_q.din    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cfgw_xfer_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_req),
        .inc  (accept),
        .count(xfer_count)
    );

    assign cfg_cs_n   = st_q.cs_n;
    assign cfg_rdwr_n = st_q.rdwr_n;
    assign cfg_din    = st_q.din;
endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker
    import cfgw_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter bit WAIT_ON_BUSY = 1'b0,
    parameter int ADDR_W       = 4,
    parameter int CNT_W        = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              hst_we,
    input logic [ADDR_W-1:0] hst_waddr,
    input logic [31:0]       hst_wdata,
    input logic              cfg_cs_n,
    input logic              cfg_rdwr_n,
    input logic [DATA_W-1:0] cfg_din,
    input logic              cfg_busy,
    input logic [CNT_W-1:0]  count
);
    logic wr_push, wr_clr, held;
    assign wr_push = hst_we && (hst_waddr == ADDR_W'(ADR_PUSH));
    assign wr_clr  = hst_we && (hst_waddr == ADDR_W'(ADR_CTRL)) && hst_wdata[CTRL_CLR_BIT];
    assign held    = WAIT_ON_BUSY && !cfg_cs_n && cfg_busy;

    AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_push && !held) |=> !cfg_cs_n); // R1
    AST_BYTE_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (wr_push && !held) |=> (cfg_din[0] == $past(hst_wdata[7]) && cfg_din[7] == $past(hst_wdata[0]))); // R2
    AST_WRITE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !cfg_cs_n |-> !cfg_rdwr_n); // R4
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!wr_push && !held) |=> cfg_cs_n); // R5
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!WAIT_ON_BUSY && !cfg_cs_n && cfg_busy && !wr_push) |=> cfg_cs_n); // R6
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        held |=> (!cfg_cs_n && $stable(cfg_din))); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!cfg_cs_n && !held && !wr_clr) |=> ((count - $past(count)) == CNT_W'(1))); // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> (count == '0)); // R9
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (cfg_cs_n && cfg_rdwr_n && count == '0)); // R11
endmodule

bind cfgport_writer cfgw_checker #(
    .DATA_W      (DATA_W),
    .WAIT_ON_BUSY(WAIT_ON_BUSY),
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hst_we    (hst_we),
    .hst_waddr (hst_waddr),
    .hst_wdata (hst_wdata),
    .cfg_cs_n  (cfg_cs_n),
    .cfg_rdwr_n(cfg_rdwr_n),
    .cfg_din   (cfg_din),
    .cfg_busy  (cfg_busy),
    .count     (xfer_count)
);

// File: tb/sim_cfgport_writer.sv
module sim_cfgport_writer;
    logic        clk = 1'b0;
    logic        rst;
    logic        we;
    logic [3:0]  waddr;
    logic [31:0] wdata;
    logic [3:0]  raddr;
    logic        busy;
    logic [31:0] dout;

    logic [31:0] rdata0, rdata1, rdata2;
    logic        cs0, cs1, cs2, rw0, rw1, rw2;
    logic [15:0] din0;
    logic [31:0] din1;
    logic [7:0]  din2;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cfgport_writer #(.DATA_W(16)) u0 (
        .clk(clk), .rst(rst), .hst_we(we), .hst_waddr(waddr), .hst_wdata(wdata),
        .hst_raddr(raddr), .hst_rdata(rdata0), .cfg_cs_n(cs0), .cfg_rdwr_n(rw0),
        .cfg_din(din0), .cfg_dout(dout[15:0]), .cfg_busy(busy));

    cfgport_writer #(.DATA_W(32), .WAIT_ON_BUSY(1'b1)) u1 (
        .clk(clk), .rst(rst), .hst_we(we), .hst_waddr(waddr), .hst_wdata(wdata),
        .hst_raddr(raddr), .hst_rdata(rdata1), .cfg_cs_n(cs1), .cfg_rdwr_n(rw1),
        .cfg_din(din1), .cfg_dout(dout), .cfg_busy(busy));

    cfgport_writer #(.DATA_W(8)) u2 (
        .clk(clk), .rst(rst), .hst_we(we), .hst_waddr(waddr), .hst_wdata(wdata),
        .hst_raddr(raddr), .hst_rdata(rdata2), .cfg_cs_n(cs2), .cfg_rdwr_n(rw2),
        .cfg_din(din2), .cfg_dout(dout[7:0]), .cfg_busy(busy));

    // {host word, expected 16-bit mirrored word}
    localparam logic [47:0] VEC [0:4] = '{
        48'h0000_0001_0080,
        48'h0000_8000_0100,
        48'h0001_2345_C4A2,
        48'hDEAD_F00F_0FF0,
        48'h0000_1E6B_78D6
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic push(input logic [3:0] a, input logic [31:0] d);
        we = 1'b1; waddr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        raddr = a;
        #1;
    endtask

    initial begin
        repeat (50000) @(negedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; we = 1'b0; waddr = '0; wdata = '0; raddr = '0; busy = 1'b0; dout = '0;
        repeat (3) @(negedge clk);
        chk(cs0 && cs1 && cs2, "R11 cs high in reset", {31'd0, cs0}, 32'd1);
        chk(rw0 && rw1, "R11 rdwr high in reset", {31'd0, rw0}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(!rw0 && !rw1 && !rw2, "R4 write level after reset", {31'd0, rw0}, 32'd0);
        chk(cs0, "R5 idle after reset", {31'd0, cs0}, 32'd1);
        rd(4'd2);
        chk(rdata0 == 32'd0, "R11 count zero", rdata0, 32'd0);

        // vector table
        for (int i = 0; i < 5; i++) begin
            push(4'd0, VEC[i][47:16]);
            chk(!cs0, "R1 cs low after push", {31'd0, cs0}, 32'd0);
            chk(din0 == VEC[i][15:0], "R2 mirrored word", {16'd0, din0}, {16'd0, VEC[i][15:0]});
            if (i == 3) chk(din1 == 32'h7BB5_0FF0, "R3 32-bit mirror", din1, 32'h7BB5_0FF0);
            if (i == 4) chk(din2 == 8'hD6, "R3 8-bit mirror", {24'd0, din2}, 32'hD6);
            @(negedge clk);
            chk(cs0, "R5 cs high when idle", {31'd0, cs0}, 32'd1);
        end
        rd(4'd2);
        chk(rdata0 == 32'd5, "R8 count after table", rdata0, 32'd5);
        chk(rdata1 == 32'd5, "R8 count after table u1", rdata1, 32'd5);

        // back-to-back pushes
        we = 1'b1; waddr = 4'd0; wdata = VEC[1][47:16];
        @(negedge clk);
        chk(!cs0 && din0 == 16'h0100, "R1 first of pair", {16'd0, din0}, 32'h0100);
        wdata = VEC[2][47:16];
        @(negedge clk);
        chk(!cs0 && din0 == 16'hC4A2, "R1 second of pair", {16'd0, din0}, 32'hC4A2);
        we = 1'b0;
        @(negedge clk);
        chk(cs0, "R5 high after pair", {31'd0, cs0}, 32'd1);
        rd(4'd2);
        chk(rdata0 == 32'd7, "R8 count after pair", rdata0, 32'd7);

        // writes elsewhere
        push(4'd1, 32'd0);
        chk(cs0, "R12 ctrl write no push", {31'd0, cs0}, 32'd1);
        push(4'd5, 32'hFFFF_FFFF);
        chk(cs0, "R12 unmapped write no push", {31'd0, cs0}, 32'd1);
        rd(4'd2);
        chk(rdata0 == 32'd7, "R9 clear bit zero keeps count", rdata0, 32'd7);

        // busy: ignored by u0, honoured by u1
        busy = 1'b1;
        push(4'd0, 32'h0000_00A1);
        chk(!cs1 && din1 == 32'h85, "R7 u1 word presented", din1, 32'h85);
        @(negedge clk);
        chk(cs0, "R6 busy ignored", {31'd0, cs0}, 32'd1);
        chk(!cs1 && din1 == 32'h85, "R7 u1 holds while busy", din1, 32'h85);
        rd(4'd3);
        chk(rdata1 == 32'd3, "R10 status in flight and busy", rdata1, 32'd3);
        chk(rdata0 == 32'd2, "R10 status busy only", rdata0, 32'd2);
        push(4'd0, 32'h0000_0003);
        chk(!cs1 && din1 == 32'h85, "R7 push during hold dropped", din1, 32'h85);
        chk(!cs0 && din0 == 16'h00C0, "R6 u0 takes push under busy", {16'd0, din0}, 32'hC0);
        busy = 1'b0;
        @(negedge clk);
        chk(cs1, "R7 released when busy low", {31'd0, cs1}, 32'd1);
        rd(4'd2);
        chk(rdata1 == 32'd8, "R8 u1 count held word once", rdata1, 32'd8);
        chk(rdata0 == 32'd9, "R8 u0 count", rdata0, 32'd9);

        // clear
        push(4'd1, 32'd1);
        rd(4'd2);
        chk(rdata0 == 32'd0, "R9 clear", rdata0, 32'd0);
        we = 1'b1; waddr = 4'd0; wdata = 32'd1;
        @(negedge clk);
        waddr = 4'd1;
        @(negedge clk);
        we = 1'b0;
        rd(4'd2);
        chk(rdata0 == 32'd0, "R9 clear wins", rdata0, 32'd0);

        // readback
        dout = 32'h1234_5678;
        rd(4'd4);
        chk(rdata0 == 32'h5678, "R10 readback 16", rdata0, 32'h5678);
        chk(rdata1 == 32'h1234_5678, "R10 readback 32", rdata1, 32'h1234_5678);
        chk(rdata2 == 32'h78, "R10 readback 8", rdata2, 32'h78);
        rd(4'd9);
        chk(rdata0 == 32'd0, "R10 unmapped read", rdata0, 32'd0);

        // reset with a word in flight
        push(4'd0, 32'h55);
        rst = 1'b1;
        @(negedge clk);
        chk(cs0 && rw0, "R11 reset mid transfer", {30'd0, rw0, cs0}, 32'd3);
        rd(4'd2);
        chk(rdata0 == 32'd0, "R11 count cleared", rdata0, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule